// File: doc/BRIEF.md
# Host Register Port for a Serial Bus Controller

This block is the host-facing register port of a serial bus controller. A host picks a register with four address pins and moves data with separate read and write strobes. Two address sources are combined. The pins are ORed bit by bit with a four-bit address field kept in the control register. The host can address registers directly through the pins while the field is zero. It can also load the field first and then access registers with the pins held low.

The port holds the control register and the two command words, and it captures the two reply status words when the sequencer loads them. It collects error bits from the sequencer and clears them when a new message sequence begins. It also builds a status word from the valid-message, error and receive-empty flags. Writes to the transmit-FIFO address produce a push strobe with the data. Reads of the receive-FIFO address return the FIFO head, and a pop strobe follows when the read ends. A message sequence begins with a one-cycle start pulse. The pulse comes from a rising edge on an external start pin, which is synchronized first, or from a host write that changes the start bit of the control register from 0 to 1.

The control register sits at address 15, so it can be reached by driving all pins high whatever the address field holds.

Top module: `bchp_host_port`

## Requirements
- R1: The effective register address is `adr_pin | ctrl[10:7]`. A read with the pins at 0 selects the register named by the control field, and a read with the field at 0 selects the register named by the pins.
- R2: A write happens once, at the first clock edge where `wr_stb` is seen high after being low. Changing `wdata` while the strobe stays high does not alter the register.
- R3: `rdata` follows the selected register combinationally. The address map is: 1 command word 1, 2 command word 2, 3 status word 1, 4 status word 2, 5 error, 6 status, 8 receive FIFO head, 15 control. Address 7 and addresses 9 to 14 read as 0. After reset every stored register reads 0.
- R4: A rising edge on `start_pin` gives `start_pulse` high for exactly one cycle, at the third clock edge after the pin rises. Holding the pin high gives no further pulse.
- R5: A write to the control register that changes bit 1 from 0 to 1 raises `start_pulse` at the write's clock edge for one cycle. Writing 1 while bit 1 is already 1, or writing 0, gives no pulse. The bit never clears by itself.
- R6: Status register bit 3 equals `rx_empty_i`, bit 7 equals `valid_msg_i` and bit 8 equals `error_i`. All other status bits read 0.
- R7: The error register ORs in `err_bits_i` on every cycle and keeps its bits until the cycle of a start pulse. On that cycle it is reloaded with only that cycle's `err_bits_i`.
- R8: Command words 1 and 2 are written by the host, read back at their addresses, and driven on `cmd1_o` and `cmd2_o`.
- R9: Status word 1 or 2 takes `seq_word_i` on a clock edge where `stw1_ld` or `stw2_ld` is high, respectively.
- R10: A write to address 7 raises `tx_push_o` for one cycle, with `tx_data_o` holding the written data, at the write's clock edge.
- R11: A read of address 8 shows `rx_data_i` on `rdata`. One cycle after `rd_stb` falls, `rx_pop_o` is high for exactly one cycle. A read strobe at any other address gives no pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adr_pin | input | 4 | Host address pins |
| wr_stb | input | 1 | Host write strobe, level |
| rd_stb | input | 1 | Host read strobe, level |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data, combinational |
| start_pin | input | 1 | External start request, asynchronous |
| start_pulse | output | 1 | One-cycle message sequence start |
| cmd1_o | output | 16 | Command word 1 to sequencer |
| cmd2_o | output | 16 | Command word 2 to sequencer |
| seq_word_i | input | 16 | Status word from sequencer |
| stw1_ld | input | 1 | Load status word 1 |
| stw2_ld | input | 1 | Load status word 2 |
| valid_msg_i | input | 1 | Valid-message flag |
| error_i | input | 1 | Message error flag |
| rx_empty_i | input | 1 | Receive FIFO empty flag |
| err_bits_i | input | 16 | Error bits reported this cycle |
| tx_push_o | output | 1 | Transmit FIFO push strobe |
| tx_data_o | output | 16 | Transmit FIFO push data |
| rx_data_i | input | 16 | Receive FIFO head word |
| rx_pop_o | output | 1 | Receive FIFO pop strobe |

## Verification
The bench sweeps all 256 combinations of control field and pin value against a model of the address map. A design that used only one address source, or that muxed the two sources instead of ORing them, would return the wrong register for most of the grid. The bench holds the write strobe high while changing the data, which exposes a level-sensitive write that would overwrite the register. It rewrites the start bit while the bit is already 1, and holds the start pin high, which catches start logic that is level-triggered rather than edge-triggered. The error register is checked both before and after a start pulse, and the receive pop is checked against reads at other addresses.

// File: rtl/bchp_pkg.sv
package bchp_pkg;
  localparam int ADR_W = 4;

  typedef enum logic [ADR_W-1:0] {
    RA_NONE = 4'd0,
    RA_CMD1 = 4'd1,
    RA_CMD2 = 4'd2,
    RA_STW1 = 4'd3,
    RA_STW2 = 4'd4,
    RA_ERR  = 4'd5,
    RA_STAT = 4'd6,
    RA_TXF  = 4'd7,
    RA_RXF  = 4'd8,
    RA_CTRL = 4'd15
  } reg_addr_e;

  localparam int ST_EMPTY_BIT = 3;
  localparam int ST_VALID_BIT = 7;
  localparam int ST_ERROR_BIT = 8;
endpackage

// File: rtl/bchp_edge.sv
module bchp_edge #(
  parameter int SYNC_STAGES = 0,
  parameter bit RISE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic pulse
);
  logic cur;
  logic prev;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign cur = d;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) begin
          sr <= '0;
        end else begin
          sr[0] <= d;
          for (int i = 1; i < SYNC_STAGES; i++) sr[i] <= sr[i-1];
        end
      end
      assign cur = sr[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= cur;
  end

  generate
    if (RISE) begin : g_rise
      assign pulse = cur & ~prev;
    end else begin : g_fall
      assign pulse = ~cur & prev;
    end
  endgenerate

  p_edge_single_r4: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/bchp_start_gen.sv
module bchp_start_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic ctrl_rise_i,
  output logic start_o
);
  logic pin_edge;

  bchp_edge #(.SYNC_STAGES(SYNC_STAGES), .RISE(1'b1)) u_pin_edge (
    .clk(clk), .rst(rst), .d(pin_i), .pulse(pin_edge)
  );

  always_ff @(posedge clk) begin
    if (rst) start_o <= 1'b0;
    else     start_o <= pin_edge | ctrl_rise_i;
  end

  p_ctrl_start_r5: assert property (@(posedge clk) disable iff (rst)
    ctrl_rise_i |=> start_o);
  p_pin_start_r4: assert property (@(posedge clk) disable iff (rst)
    pin_edge |=> start_o);
endmodule

// File: rtl/bchp_err_accum.sv
module bchp_err_accum #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic [DW-1:0] set_i,
  output logic [DW-1:0] err_o
);
  always_ff @(posedge clk) begin
    if (rst)          err_o <= '0;
    else if (clear_i) err_o <= set_i;
    else              err_o <= err_o | set_i;
  end

  p_err_clear_r7: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (err_o == $past(set_i)));
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    !clear_i |=> ((err_o & $past(err_o)) == $past(err_o)));
endmodule

// File: rtl/bchp_host_port.sv
module bchp_host_port
  import bchp_pkg::*;
#(
  parameter int DW           = 16,
  parameter int CTRL_ADR_LSB = 7,
  parameter int START_BIT    = 1,
  parameter int PIN_SYNC     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ADR_W-1:0] adr_pin,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic             start_pin,
  output logic             start_pulse,
  output logic [DW-1:0]    cmd1_o,
  output logic [DW-1:0]    cmd2_o,
  input  logic [DW-1:0]    seq_word_i,
  input  logic             stw1_ld,
  input  logic             stw2_ld,
  input  logic             valid_msg_i,
  input  logic             error_i,
  input  logic             rx_empty_i,
  input  logic [DW-1:0]    err_bits_i,
  output logic             tx_push_o,
  output logic [DW-1:0]    tx_data_o,
  input  logic [DW-1:0]    rx_data_i,
  output logic             rx_pop_o
);
  localparam int CTRL_ADR_MSB = CTRL_ADR_LSB + ADR_W - 1;

  logic [DW-1:0]    ctrl_q, cmd1_q, cmd2_q, stw1_q, stw2_q, err_q, stat_w;
  logic [ADR_W-1:0] eff_adr;
  logic             wr_fire, rd_rise, rd_fall, rd_on_rx, ctrl_rise;

  assign eff_adr = adr_pin | ctrl_q[CTRL_ADR_MSB:CTRL_ADR_LSB];

  bchp_edge #(.SYNC_STAGES(0), .RISE(1'b1)) u_wr_edge (
    .clk(clk), .rst(rst), .d(wr_stb), .pulse(wr_fire)
  );
  bchp_edge #(.SYNC_STAGES(0), .RISE(1'b1)) u_rd_rise (
    .clk(clk), .rst(rst), .d(rd_stb), .pulse(rd_rise)
  );
  bchp_edge #(.SYNC_STAGES(0), .RISE(1'b0)) u_rd_fall (
    .clk(clk), .rst(rst), .d(rd_stb), .pulse(rd_fall)
  );

  assign ctrl_rise = wr_fire && (eff_adr == RA_CTRL) &&
                     wdata[START_BIT] && !ctrl_q[START_BIT];

  bchp_start_gen #(.SYNC_STAGES(PIN_SYNC)) u_start (
    .clk(clk), .rst(rst), .pin_i(start_pin),
    .ctrl_rise_i(ctrl_rise), .start_o(start_pulse)
  );

  bchp_err_accum #(.DW(DW)) u_err (
    .clk(clk), .rst(rst), .clear_i(start_pulse),
    .set_i(err_bits_i), .err_o(err_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cmd1_q <= '0;
      cmd2_q <= '0;
    end else if (wr_fire) begin
      case (eff_adr)
        RA_CTRL: ctrl_q <= wdata;
        RA_CMD1: cmd1_q <= wdata;
        RA_CMD2: cmd2_q <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stw1_q <= '0;
      stw2_q <= '0;
    end else begin
      if (stw1_ld) stw1_q <= seq_word_i;
      if (stw2_ld) stw2_q <= seq_word_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_push_o <= 1'b0;
      tx_data_o <= '0;
    end else begin
      tx_push_o <= wr_fire && (eff_adr == RA_TXF);
      if (wr_fire && (eff_adr == RA_TXF)) tx_data_o <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_on_rx <= 1'b0;
      rx_pop_o <= 1'b0;
    end else begin
      if (rd_rise) rd_on_rx <= (eff_adr == RA_RXF);
      rx_pop_o <= rd_fall && rd_on_rx;
    end
  end

  always_comb begin
    stat_w = '0;
    stat_w[ST_EMPTY_BIT] = rx_empty_i;
    stat_w[ST_VALID_BIT] = valid_msg_i;
    stat_w[ST_ERROR_BIT] = error_i;
  end

  always_comb begin
    case (eff_adr)
      RA_CTRL: rdata = ctrl_q;
      RA_CMD1: rdata = cmd1_q;
      RA_CMD2: rdata = cmd2_q;
      RA_STW1: rdata = stw1_q;
      RA_STW2: rdata = stw2_q;
      RA_ERR:  rdata = err_q;
      RA_STAT: rdata = stat_w;
      RA_RXF:  rdata = rx_data_i;
      default: rdata = '0;
    endcase
  end

  assign cmd1_o = cmd1_q;
  assign cmd2_o = cmd2_q;

  p_write_once_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && $past(wr_stb)) |=> ($stable(ctrl_q) && $stable(cmd1_q) && $stable(cmd2_q)));
  p_txpush_single_r10: assert property (@(posedge clk) disable iff (rst)
    tx_push_o |=> !tx_push_o);
  p_rxpop_single_r11: assert property (@(posedge clk) disable iff (rst)
    rx_pop_o |=> !rx_pop_o);
  p_pop_after_fall_r11: assert property (@(posedge clk) disable iff (rst)
    rx_pop_o |-> $fell(rd_stb) || $past(!rd_stb));
endmodule

// File: tb/bchp_host_port_tb.sv
module bchp_host_port_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  adr_pin;
  logic        wr_stb, rd_stb, start_pin, start_pulse;
  logic [15:0] wdata, rdata, cmd1_o, cmd2_o, seq_word_i, err_bits_i;
  logic        stw1_ld, stw2_ld, valid_msg_i, error_i, rx_empty_i;
  logic        tx_push_o, rx_pop_o;
  logic [15:0] tx_data_o, rx_data_i;

  int total = 0;
  int bad = 0;
  int pcnt = 0;
  bit done = 1'b0;

  logic [15:0] m_ctrl, m_cmd1, m_cmd2, m_stw1, m_stw2, m_err;

  always #4 clk = ~clk;

  bchp_host_port dut_i (
    .clk(clk), .rst(rst), .adr_pin(adr_pin), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wdata(wdata), .rdata(rdata), .start_pin(start_pin), .start_pulse(start_pulse),
    .cmd1_o(cmd1_o), .cmd2_o(cmd2_o), .seq_word_i(seq_word_i), .stw1_ld(stw1_ld),
    .stw2_ld(stw2_ld), .valid_msg_i(valid_msg_i), .error_i(error_i),
    .rx_empty_i(rx_empty_i), .err_bits_i(err_bits_i), .tx_push_o(tx_push_o),
    .tx_data_o(tx_data_o), .rx_data_i(rx_data_i), .rx_pop_o(rx_pop_o)
  );

  always @(posedge clk) if (!rst && start_pulse) pcnt <= pcnt + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_reg(input int a);
    logic [15:0] s;
    s = '0;
    s[3] = rx_empty_i;
    s[7] = valid_msg_i;
    s[8] = error_i;
    case (a)
      1: return m_cmd1;
      2: return m_cmd2;
      3: return m_stw1;
      4: return m_stw2;
      5: return m_err;
      6: return s;
      8: return rx_data_i;
      15: return m_ctrl;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic host_write(input logic [3:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    adr_pin = a; wdata = d; wr_stb = 1'b1;
    @(posedge clk); #1;
    wr_stb = 1'b0;
    if (a == 4'd15) m_ctrl = d;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p0;
    rst = 1'b1; adr_pin = '0; wr_stb = 0; rd_stb = 0; wdata = '0; start_pin = 0;
    seq_word_i = '0; stw1_ld = 0; stw2_ld = 0; valid_msg_i = 0; error_i = 0;
    rx_empty_i = 1; err_bits_i = '0; rx_data_i = 16'hA5C3;
    m_ctrl = '0; m_cmd1 = '0; m_cmd2 = '0; m_stw1 = '0; m_stw2 = '0; m_err = '0;
    tick(3);
    rst = 1'b0;
    tick(1);

    // reset state (R3)
    chk("R3 reset start_pulse", start_pulse, 0);
    chk("R3 reset tx_push", tx_push_o, 0);
    chk("R3 reset rx_pop", rx_pop_o, 0);
    adr_pin = 4'd15; #1 chk("R3 reset ctrl", rdata, 0);
    adr_pin = 4'd1;  #1 chk("R3 reset cmd1", rdata, 0);

    // R8 command words
    host_write(4'd1, 16'h1234); m_cmd1 = 16'h1234;
    host_write(4'd2, 16'hBEEF); m_cmd2 = 16'hBEEF;
    chk("R8 cmd1_o", cmd1_o, 16'h1234);
    chk("R8 cmd2_o", cmd2_o, 16'hBEEF);
    adr_pin = 4'd2; #1 chk("R8 cmd2 read", rdata, 16'hBEEF);

    // R9 status word capture
    seq_word_i = 16'h0C01; stw1_ld = 1; tick(1); stw1_ld = 0;
    seq_word_i = 16'h0D02; stw2_ld = 1; tick(1); stw2_ld = 0;
    seq_word_i = 16'hFFFF; tick(1);
    m_stw1 = 16'h0C01; m_stw2 = 16'h0D02;
    adr_pin = 4'd3; #1 chk("R9 stw1", rdata, 16'h0C01);
    adr_pin = 4'd4; #1 chk("R9 stw2", rdata, 16'h0D02);

    // R6 status flags, all combinations
    adr_pin = 4'd6;
    for (int k = 0; k < 8; k++) begin
      rx_empty_i = k[0]; valid_msg_i = k[1]; error_i = k[2];
      #1 chk("R6 status", rdata, {7'd0, k[2], k[1], 3'd0, k[0], 3'd0});
    end

    // R1/R3 address sweep over field x pins
    rx_empty_i = 0; valid_msg_i = 1; error_i = 0;
    for (int f = 0; f < 16; f++) begin
      host_write(4'd15, 16'(f) << 7);
      for (int p = 0; p < 16; p++) begin
        adr_pin = 4'(p);
        #1 chk("R1 eff addr", rdata, exp_reg(f | p));
      end
    end
    host_write(4'd15, 16'h0000);
    adr_pin = 4'd1; #1 chk("R1 pins only", rdata, 16'h1234);

    // R2 held strobe
    @(posedge clk); #1;
    adr_pin = 4'd1; wdata = 16'h5555; wr_stb = 1;
    tick(1); wdata = 16'h6666; tick(3); wr_stb = 0; tick(1);
    m_cmd1 = 16'h5555;
    chk("R2 single write", cmd1_o, 16'h5555);

    // R10 transmit push
    host_write(4'd7, 16'h3C3C);
    chk("R10 push", tx_push_o, 1);
    chk("R10 data", tx_data_o, 16'h3C3C);
    tick(1);
    chk("R10 push one cycle", tx_push_o, 0);

    // R11 receive pop
    @(posedge clk); #1;
    adr_pin = 4'd8; rd_stb = 1;
    #1 chk("R11 rx head", rdata, 16'hA5C3);
    tick(2);
    chk("R11 no pop during read", rx_pop_o, 0);
    rd_stb = 0; tick(1);
    chk("R11 pop", rx_pop_o, 1);
    tick(1);
    chk("R11 pop one cycle", rx_pop_o, 0);
    adr_pin = 4'd3; rd_stb = 1; tick(2); rd_stb = 0; tick(1);
    chk("R11 no pop other addr", rx_pop_o, 0);

    // R7 error accumulation
    err_bits_i = 16'h0003; tick(1);
    err_bits_i = 16'h0010; tick(1);
    err_bits_i = 16'h0000; tick(1);
    adr_pin = 4'd5; #1 chk("R7 accumulate", rdata, 16'h0013);

    // R4 pin start
    p0 = pcnt;
    start_pin = 1; tick(2);
    chk("R4 no early pulse", start_pulse, 0);
    tick(1);
    chk("R4 pulse at third edge", start_pulse, 1);
    tick(1);
    chk("R4 pulse one cycle", start_pulse, 0);
    tick(6);
    chk("R4 held pin single pulse", pcnt - p0, 1);
    adr_pin = 4'd5; #1 chk("R7 cleared by start", rdata, 16'h0000);
    start_pin = 0; tick(4);

    // R5 control bit start
    p0 = pcnt;
    host_write(4'd15, 16'h0002);
    chk("R5 ctrl rise pulse", start_pulse, 1);
    tick(1);
    chk("R5 pulse one cycle", start_pulse, 0);
    host_write(4'd15, 16'h0002);
    chk("R5 rewrite 1 no pulse", start_pulse, 0);
    adr_pin = 4'd15; #1 chk("R5 bit stays set", rdata, 16'h0002);
    host_write(4'd15, 16'h0000);
    chk("R5 write 0 no pulse", start_pulse, 0);
    host_write(4'd15, 16'h0002);
    chk("R5 second rise pulse", start_pulse, 1);
    tick(2);
    chk("R5 pulse count", pcnt - p0, 2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule